// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two lowest address bits for a synchronous burst memory. A load strobe captures a start value from the low bits of the external address bus; after that, each cycle in which the active-low advance input is low moves the output to the next beat of a four-beat burst. The order of the beats is chosen by a mode input: low selects linear order (add one, modulo four), high selects interleaved order (start value XOR beat number). The upper address bits, the storage array and the chip-select logic sit outside the block.

The sequencer is a small state machine with five named states: `ST_IDLE` (nothing loaded since reset), and `ST_BEAT0`, `ST_BEAT1`, `ST_BEAT2`, `ST_BEAT3` (the beat number of the burst in progress). Its transitions are: *load* (any state to `ST_BEAT0` when the strobe is high, capturing the start value), *step* (`ST_BEATk` to `ST_BEAT(k+1)` when advance is low and no load), *wrap* (`ST_BEAT3` to `ST_BEAT0` on a step), *hold* (any beat state to itself when advance is high and no load), and *idle-stay* (`ST_IDLE` to itself without a load). The output is formed combinationally from the stored start value, the beat number and the current mode, so a fresh load on every cycle gives a plain non-burst access per cycle.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is asserted and after it, until the first load, the output `beat_addr` is 2'b00.
- R2: One clock edge with `load` high makes `beat_addr` equal the `start_lo` value presented at that edge, in either mode.
- R3: With `order_sel` = 0 (linear), each edge with `adv_n` = 0 and `load` = 0 during a burst makes the output the previous output plus one modulo 4 (start 01 gives 01, 10, 11, 00).
- R4: With `order_sel` = 1 (interleaved), after k advances the output is the start value XOR k (start 01 gives 01, 00, 11, 10).
- R5: The fourth advance after a load returns the output to the start value, and the sequence repeats.
- R6: An edge with `adv_n` = 1 and `load` = 0 leaves the output unchanged while the mode is unchanged.
- R7: When `load` and `adv_n` = 0 coincide, the load wins: the output becomes the new start value and the beat number restarts at zero.
- R8: A load on every consecutive cycle yields each cycle's start value in turn, with no burst stepping.
- R9: Advance requests before the first load after reset have no effect; the output stays 2'b00.
- R10: The mode input is applied continuously: changing `order_sel` in a held burst changes the output at once to the other order's address for the same start value and beat number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start strobe; captures `start_lo` and restarts the burst |
| adv_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| start_lo | input | 2 | Low address bits used as the burst start value |
| beat_addr | output | 2 | Current low address bits of the burst |

## Verification
The hardest situation to reach is the wrap from the fourth beat back to the start for every start value in both orders, since it needs a load followed by exactly four uninterrupted advances. The bench walks a table of all eight mode/start pairs, each loaded and then advanced four times, comparing all five outputs. Collisions of load with advance, holds in the middle of a burst and a mode change in a held burst are then driven as directed cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LO_W      = 2;
    localparam int BURST_LEN = 1 << LO_W;

    typedef logic [LO_W-1:0] lo_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } beat_state_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  logic     adv_n_i,
    input  lo_addr_t start_i,
    output lo_addr_t start_o,
    output lo_addr_t beat_o,
    output logic     busy_o
);

    beat_state_e state_q, state_d;
    lo_addr_t    start_q;

    // state register and start capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) begin
                start_q <= start_i;
            end
        end
    end

    // next-state: load beats everything, then step, else hold
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_BEAT0;
        end else if (!adv_n_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        beat_o = '0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_BEAT0: beat_o = lo_addr_t'(0);
            ST_BEAT1: beat_o = lo_addr_t'(1);
            ST_BEAT2: beat_o = lo_addr_t'(2);
            ST_BEAT3: beat_o = lo_addr_t'(3);
            default:  busy_o = 1'b0;
        endcase
    end

    assign start_o = start_q;

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_i) |=> (state_q == ST_IDLE)); // R9

    AST_WRAP_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT3 && !load_i && !adv_n_i) |=> (state_q == ST_BEAT0)); // R5

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q == ST_BEAT0 && start_q == $past(start_i))); // R7

endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
    import burst_seq_pkg::*;
(
    input  logic     order_sel_i,
    input  lo_addr_t start_i,
    input  lo_addr_t beat_i,
    output lo_addr_t addr_o
);

    always_comb begin
        unique case (order_sel_i)
            1'b0:    addr_o = lo_addr_t'(start_i + beat_i);
            1'b1:    addr_o = start_i ^ beat_i;
            default: addr_o = start_i;
        endcase
    end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       adv_n,
    input  logic       order_sel,
    input  logic [1:0] start_lo,
    output logic [1:0] beat_addr
);

    lo_addr_t start_q;
    lo_addr_t beat_q;
    logic     busy;

    burst_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .adv_n_i (adv_n),
        .start_i (start_lo),
        .start_o (start_q),
        .beat_o  (beat_q),
        .busy_o  (busy)
    );

    burst_seq_order u_order (
        .order_sel_i (order_sel),
        .start_i     (start_q),
        .beat_i      (beat_q),
        .addr_o      (beat_addr)
    );

    AST_LOAD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_addr == $past(start_lo))); // R2

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> (!$stable(order_sel) || $stable(beat_addr))); // R6

    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !adv_n && !order_sel)
        |=> (order_sel || beat_addr == 2'($past(beat_addr) + 2'd1))); // R3

    AST_IL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !adv_n && order_sel)
        |=> (!order_sel || (beat_addr ^ start_q) == 2'($past(beat_addr ^ start_q) + 2'd1))); // R4

endmodule

// File: tb/burst_seq_gen_bench.sv
module burst_seq_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       adv_n = 1'b1;
    logic       order_sel = 1'b1;
    logic [1:0] start_lo = 2'b00;
    logic [1:0] beat_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_seq_gen u_burst_seq_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .adv_n     (adv_n),
        .order_sel (order_sel),
        .start_lo  (start_lo),
        .beat_addr (beat_addr)
    );

    // [12] mode, [11:10] start, [9:0] five expected beats, first beat in MSBs
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
        {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
        {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
        {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3},
        {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
        {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
        {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
        {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3}
    };

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if (beat_addr !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, beat_addr, exp);
        end
    endtask

    task automatic cyc(input logic l, input logic a, input logic m, input logic [1:0] s);
        @(negedge clk);
        load = l; adv_n = a; order_sel = m; start_lo = s;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2 chk("R1 in reset", 2'b00);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 after reset", 2'b00);

        // R9: advance with nothing loaded
        cyc(1'b0, 1'b0, 1'b0, 2'd3); chk("R9 idle adv lin", 2'b00);
        cyc(1'b0, 1'b0, 1'b1, 2'd2); chk("R9 idle adv il", 2'b00);

        // table: load then four advances, R2 R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 1'b1, VEC[i][12], VEC[i][11:10]);
            chk("R2 load", VEC[i][9:8]);
            for (int b = 1; b < 5; b++) begin
                cyc(1'b0, 1'b0, VEC[i][12], 2'd0);
                if (b == 4) chk("R5 wrap", VEC[i][1:0]);
                else if (VEC[i][12]) chk("R4 interleaved", VEC[i][9-2*b -: 2]);
                else chk("R3 linear", VEC[i][9-2*b -: 2]);
            end
        end

        // R6: hold mid burst
        cyc(1'b1, 1'b1, 1'b0, 2'd2); chk("R2 load", 2'b10);
        cyc(1'b0, 1'b0, 1'b0, 2'd0); chk("R3 step", 2'b11);
        cyc(1'b0, 1'b1, 1'b0, 2'd1); chk("R6 hold", 2'b11);
        cyc(1'b0, 1'b1, 1'b0, 2'd0); chk("R6 hold", 2'b11);
        cyc(1'b0, 1'b0, 1'b0, 2'd0); chk("R6 resume", 2'b00);

        // R7: load collides with advance, beat restarts
        cyc(1'b1, 1'b0, 1'b1, 2'd3); chk("R7 load wins", 2'b11);
        cyc(1'b0, 1'b0, 1'b1, 2'd0); chk("R7 beat1 after restart", 2'b10);
        cyc(1'b0, 1'b0, 1'b1, 2'd0); chk("R7 beat2 after restart", 2'b01);

        // R8: load every cycle
        cyc(1'b1, 1'b0, 1'b0, 2'd0); chk("R8 fresh", 2'b00);
        cyc(1'b1, 1'b0, 1'b0, 2'd3); chk("R8 fresh", 2'b11);
        cyc(1'b1, 1'b0, 1'b1, 2'd1); chk("R8 fresh", 2'b01);
        cyc(1'b1, 1'b0, 1'b1, 2'd2); chk("R8 fresh", 2'b10);

        // R10: mode change in a held burst, start 01 at beat 1
        cyc(1'b1, 1'b1, 1'b0, 2'd1); chk("R2 load", 2'b01);
        cyc(1'b0, 1'b0, 1'b0, 2'd0); chk("R3 step", 2'b10);
        cyc(1'b0, 1'b1, 1'b1, 2'd0); chk("R10 to interleaved", 2'b00);
        cyc(1'b0, 1'b1, 1'b0, 2'd0); chk("R10 back to linear", 2'b10);

        // R1: reset mid burst
        @(negedge clk) rst_n = 1'b0;
        #1 chk("R1 mid-burst reset", 2'b00);
        @(negedge clk) rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 2'd2); chk("R9 idle after reset", 2'b00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule